// File: doc/BRIEF.md
# Microsequencer Control and Branch-Test Unit

This block is the control-output and condition-test section of a small byte-oriented microsequencer inside a disk controller. Each cycle it is handed an 8-bit microinstruction byte, an execute strobe and a flag that marks the byte as a control instruction. Bits [5:2] of the byte form a 4-bit operation field. Bits 1 and 0 carry data or qualifiers for that field.

A control instruction acts on the clock edge. It can write one of the interface output flip-flops, the unit-select bit, the head-load bit or the write-buffer flag. It can also step or load the 12-bit sector buffer address, preset or shift the 16-bit CRC register, clear or count the 8-bit counter, shift the 8-bit shift register, or drive a J-K flag.

The same field also selects a branch condition. The condition is produced combinationally from the current state, so the program-counter logic next door can use it in the cycle it fetches the branch. Every register is brought out to a port. The program counter, the fetch logic and the data separator sit outside this block.

Top module: `mseq_ctrl_unit`

## Requirements
- R1: While rst_n is low, and after it rises, every output register reads zero until the first control instruction. This covers the interface bits, unit select, head load, write buffer, J-K flag, buffer address, CRC, counter and shift register.
- R2: A control instruction with field 0..6 writes instruction bit 1 into interface bit iob_o[field]. All other interface bits keep their values.
- R3: Field 7 writes instruction bit 1 into unit_sel_o. Field 8 writes instruction bit 1 into head_load_o.
- R4: Field 9 acts on the 12-bit buffer address. With bit 1 = 1 it adds one modulo 4096, so 4095 is followed by 0. With bit 1 = 0 it loads 0 when bit 0 = 1, and 3072 (octal 6000) when bit 0 = 0.
- R5: Field 10 writes instruction bit 0 into wbuf_o.
- R6: Field 11 acts on the CRC register. Bits[1:0] = 11 set it to 16'hFFFF. Bits[1:0] = 10 shift it right by one and fill the top bit with 0. Any other value of bits[1:0] leaves it unchanged.
- R7: Field 12 updates the J-K flag, with J taken from bit 1 and K from bit 0. J sets a clear flag, K clears a set flag, J=K=1 inverts the flag, and J=K=0 holds it.
- R8: Field 13 acts on the 8-bit counter. Bit 0 = 1 clears it. Otherwise bit 1 = 1 adds one modulo 256, and bit 1 = 0 holds it. Field 14 shifts the shift register left by one, with instruction bit 1 entering at bit 0.
- R9: Field 15 as a control instruction changes no register. An instruction presented with exec_i low or ctrl_i low also changes no register.
- R10: cond_o reflects the current state in the same cycle, selected by the field: 1 = iob_o[3], 4 = sr_o[7], 5 = (cnt_o == 255), 6 = crc_o[0], 11 = (sr_o[7] == sep_data_i), 12 = (bar_o == 4095), 15 = jk_flag_o.
- R11: Field values 0, 2, 3, 7, 8, 9, 10, 13 and 14 give cond_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Execute strobe for the presented instruction |
| ctrl_i | input | 1 | Instruction is a control instruction (1) rather than a branch (0) |
| instr_i | input | 8 | Microinstruction byte; [5:2] field, [1:0] data bits |
| sep_data_i | input | 1 | Separated read-data bit for the equality test |
| cond_o | output | 1 | Selected branch condition |
| iob_o | output | 7 | Interface output flip-flops |
| unit_sel_o | output | 1 | Drive unit select |
| head_load_o | output | 1 | Head load |
| wbuf_o | output | 1 | Write-buffer flag |
| jk_flag_o | output | 1 | J-K flag |
| bar_o | output | 12 | Sector buffer address |
| crc_o | output | 16 | CRC register |
| cnt_o | output | 8 | Counter |
| sr_o | output | 8 | Shift register |

## Verification
The bench builds the block with its default parameters: seven interface bits, a 12-bit buffer address, a 16-bit CRC, and an 8-bit counter and shift register. These widths are small enough that directed runs can walk the buffer address from 3072 all the way to 4095, wrap it to 0, and count the counter up to 255. That brings the two terminal-count branch tests and both wraps within reach.

Random instruction bytes, strobes and separated-data bits then cover every field in both the control and the branch role. They include the J-K set, clear, hold and toggle cases and the CRC preset and shift cases, each compared against a bench-side model.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int FIELD_W  = 4;
  localparam int N_FIELDS = 1 << FIELD_W;

  // control operation codes carried in instruction bits [5:2]
  typedef enum logic [FIELD_W-1:0] {
    OP_IOB0  = 4'd0,  OP_IOB1 = 4'd1,  OP_IOB2 = 4'd2,  OP_IOB3  = 4'd3,
    OP_IOB4  = 4'd4,  OP_IOB5 = 4'd5,  OP_IOB6 = 4'd6,  OP_UNIT  = 4'd7,
    OP_HEAD  = 4'd8,  OP_BAR  = 4'd9,  OP_WBUF = 4'd10, OP_CRC   = 4'd11,
    OP_JK    = 4'd12, OP_CNT  = 4'd13, OP_SHFT = 4'd14, OP_NONE  = 4'd15
  } ctl_op_e;

  // branch tests carried in the same field
  typedef enum logic [FIELD_W-1:0] {
    TST_IOB3   = 4'd1,
    TST_SR_MSB = 4'd4,
    TST_CNT_FL = 4'd5,
    TST_CRC_LS = 4'd6,
    TST_SEP_EQ = 4'd11,
    TST_BAR_FL = 4'd12,
    TST_FLAG   = 4'd15
  } tst_e;

  // J-K next state: J sets a clear flag, K clears a set flag
  function automatic logic jk_next(input logic q, input logic j, input logic k);
    return (j & ~q) | (~k & q);
  endfunction
endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
#(
  parameter int IOB_N = 7
) (
  input  logic                 exec_i,
  input  logic                 ctrl_i,
  input  logic [7:0]           instr_i,
  output logic [FIELD_W-1:0]   field_o,
  output logic                 d1_o,
  output logic                 d0_o,
  output logic [N_FIELDS-1:0]  op_hit_o,
  output logic [IOB_N-1:0]     wr_iob_o,
  output logic                 wr_unit_o,
  output logic                 wr_head_o,
  output logic                 wr_bar_o,
  output logic                 wr_wbuf_o,
  output logic                 wr_crc_o,
  output logic                 wr_jk_o,
  output logic                 wr_cnt_o,
  output logic                 wr_sr_o
);
  localparam int IOB_MAX = int'(OP_UNIT);

  logic fire;

  initial begin
    if (IOB_N < 4 || IOB_N > IOB_MAX)
      $error("IOB_N must lie between 4 and %0d", IOB_MAX);
  end

  assign field_o = instr_i[5:2];
  assign d1_o    = instr_i[1];
  assign d0_o    = instr_i[0];
  assign fire    = exec_i & ctrl_i;

  always_comb begin
    op_hit_o = '0;
    if (fire) op_hit_o[field_o] = 1'b1;
  end

  for (genvar g = 0; g < IOB_N; g++) begin : g_iob_wr
    assign wr_iob_o[g] = op_hit_o[g];
  end

  assign wr_unit_o = op_hit_o[OP_UNIT];
  assign wr_head_o = op_hit_o[OP_HEAD];
  assign wr_bar_o  = op_hit_o[OP_BAR];
  assign wr_wbuf_o = op_hit_o[OP_WBUF];
  assign wr_crc_o  = op_hit_o[OP_CRC];
  assign wr_jk_o   = op_hit_o[OP_JK];
  assign wr_cnt_o  = op_hit_o[OP_CNT];
  assign wr_sr_o   = op_hit_o[OP_SHFT];
endmodule

// File: rtl/mseq_state_regs.sv
module mseq_state_regs
  import mseq_pkg::*;
#(
  parameter int IOB_N = 7,
  parameter int BAR_W = 12,
  parameter int CRC_W = 16,
  parameter int CNT_W = 8,
  parameter int SR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d1_i,
  input  logic             d0_i,
  input  logic [IOB_N-1:0] wr_iob_i,
  input  logic             wr_unit_i,
  input  logic             wr_head_i,
  input  logic             wr_bar_i,
  input  logic             wr_wbuf_i,
  input  logic             wr_crc_i,
  input  logic             wr_jk_i,
  input  logic             wr_cnt_i,
  input  logic             wr_sr_i,
  output logic [IOB_N-1:0] iob_o,
  output logic             unit_o,
  output logic             head_o,
  output logic             wbuf_o,
  output logic             jk_o,
  output logic [BAR_W-1:0] bar_o,
  output logic [CRC_W-1:0] crc_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SR_W-1:0]  sr_o
);
  // load value for the "other end" of the buffer: top two bits set
  localparam logic [BAR_W-1:0] BAR_HIGH = BAR_W'(3) << (BAR_W - 2);

  function automatic logic [BAR_W-1:0] bar_next(input logic [BAR_W-1:0] cur,
                                                input logic up, input logic zero);
    if (up)        return cur + 1'b1;
    else if (zero) return '0;
    else           return BAR_HIGH;
  endfunction

  function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] cur,
                                                input logic b1, input logic b0);
    if (b1 && b0)  return '1;
    else if (b1)   return cur >> 1;
    else           return cur;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur,
                                                input logic up, input logic clr);
    if (clr)       return '0;
    else if (up)   return cur + 1'b1;
    else           return cur;
  endfunction

  function automatic logic [SR_W-1:0] sr_next(input logic [SR_W-1:0] cur,
                                              input logic din);
    return {cur[SR_W-2:0], din};
  endfunction

  for (genvar g = 0; g < IOB_N; g++) begin : g_iob_ff
    always_ff @(posedge clk) begin
      if (!rst_n)          iob_o[g] <= 1'b0;
      else if (wr_iob_i[g]) iob_o[g] <= d1_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unit_o <= 1'b0;
      head_o <= 1'b0;
      wbuf_o <= 1'b0;
      jk_o   <= 1'b0;
    end else begin
      if (wr_unit_i) unit_o <= d1_i;
      if (wr_head_i) head_o <= d1_i;
      if (wr_wbuf_i) wbuf_o <= d0_i;
      if (wr_jk_i)   jk_o   <= jk_next(jk_o, d1_i, d0_i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_o <= '0;
      crc_o <= '0;
      cnt_o <= '0;
      sr_o  <= '0;
    end else begin
      if (wr_bar_i) bar_o <= bar_next(bar_o, d1_i, d0_i);
      if (wr_crc_i) crc_o <= crc_next(crc_o, d1_i, d0_i);
      if (wr_cnt_i) cnt_o <= cnt_next(cnt_o, d1_i, d0_i);
      if (wr_sr_i)  sr_o  <= sr_next(sr_o, d1_i);
    end
  end
endmodule

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux
  import mseq_pkg::*;
#(
  parameter int IOB_N = 7,
  parameter int BAR_W = 12,
  parameter int CRC_W = 16,
  parameter int CNT_W = 8,
  parameter int SR_W  = 8
) (
  input  logic [FIELD_W-1:0]  field_i,
  input  logic [IOB_N-1:0]    iob_i,
  input  logic                jk_i,
  input  logic [BAR_W-1:0]    bar_i,
  input  logic [CRC_W-1:0]    crc_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [SR_W-1:0]     sr_i,
  input  logic                sep_i,
  output logic [N_FIELDS-1:0] src_o,
  output logic                cond_o
);
  localparam int IOB_TEST_BIT = 3;

  logic sr_msb;
  assign sr_msb = sr_i[SR_W-1];

  always_comb begin
    src_o             = '0;
    src_o[TST_IOB3]   = iob_i[IOB_TEST_BIT];
    src_o[TST_SR_MSB] = sr_msb;
    src_o[TST_CNT_FL] = &cnt_i;
    src_o[TST_CRC_LS] = crc_i[0];
    src_o[TST_SEP_EQ] = (sr_msb == sep_i);
    src_o[TST_BAR_FL] = &bar_i;
    src_o[TST_FLAG]   = jk_i;
  end

  assign cond_o = src_o[field_i];
endmodule

// File: rtl/mseq_ctrl_unit.sv
module mseq_ctrl_unit
  import mseq_pkg::*;
#(
  parameter int IOB_N = 7,
  parameter int BAR_W = 12,
  parameter int CRC_W = 16,
  parameter int CNT_W = 8,
  parameter int SR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  logic             ctrl_i,
  input  logic [7:0]       instr_i,
  input  logic             sep_data_i,
  output logic             cond_o,
  output logic [IOB_N-1:0] iob_o,
  output logic             unit_sel_o,
  output logic             head_load_o,
  output logic             wbuf_o,
  output logic             jk_flag_o,
  output logic [BAR_W-1:0] bar_o,
  output logic [CRC_W-1:0] crc_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SR_W-1:0]  sr_o
);
  logic [FIELD_W-1:0]  field;
  logic                d1, d0;
  logic [N_FIELDS-1:0] op_hit;
  logic [N_FIELDS-1:0] cond_src;
  logic [IOB_N-1:0]    wr_iob;
  logic wr_unit, wr_head, wr_bar, wr_wbuf, wr_crc, wr_jk, wr_cnt, wr_sr;

  mseq_decode #(.IOB_N(IOB_N)) u_dec (
    .exec_i   (exec_i),
    .ctrl_i   (ctrl_i),
    .instr_i  (instr_i),
    .field_o  (field),
    .d1_o     (d1),
    .d0_o     (d0),
    .op_hit_o (op_hit),
    .wr_iob_o (wr_iob),
    .wr_unit_o(wr_unit),
    .wr_head_o(wr_head),
    .wr_bar_o (wr_bar),
    .wr_wbuf_o(wr_wbuf),
    .wr_crc_o (wr_crc),
    .wr_jk_o  (wr_jk),
    .wr_cnt_o (wr_cnt),
    .wr_sr_o  (wr_sr)
  );

  mseq_state_regs #(
    .IOB_N(IOB_N), .BAR_W(BAR_W), .CRC_W(CRC_W), .CNT_W(CNT_W), .SR_W(SR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .d1_i     (d1),
    .d0_i     (d0),
    .wr_iob_i (wr_iob),
    .wr_unit_i(wr_unit),
    .wr_head_i(wr_head),
    .wr_bar_i (wr_bar),
    .wr_wbuf_i(wr_wbuf),
    .wr_crc_i (wr_crc),
    .wr_jk_i  (wr_jk),
    .wr_cnt_i (wr_cnt),
    .wr_sr_i  (wr_sr),
    .iob_o    (iob_o),
    .unit_o   (unit_sel_o),
    .head_o   (head_load_o),
    .wbuf_o   (wbuf_o),
    .jk_o     (jk_flag_o),
    .bar_o    (bar_o),
    .crc_o    (crc_o),
    .cnt_o    (cnt_o),
    .sr_o     (sr_o)
  );

  mseq_cond_mux #(
    .IOB_N(IOB_N), .BAR_W(BAR_W), .CRC_W(CRC_W), .CNT_W(CNT_W), .SR_W(SR_W)
  ) u_cond (
    .field_i(field),
    .iob_i  (iob_o),
    .jk_i   (jk_flag_o),
    .bar_i  (bar_o),
    .crc_i  (crc_o),
    .cnt_i  (cnt_o),
    .sr_i   (sr_o),
    .sep_i  (sep_data_i),
    .src_o  (cond_src),
    .cond_o (cond_o)
  );
endmodule

// File: rtl/mseq_ctrl_unit_chk.sv
module mseq_ctrl_unit_chk #(
  parameter int IOB_N = 7,
  parameter int BAR_W = 12,
  parameter int CRC_W = 16,
  parameter int CNT_W = 8,
  parameter int SR_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exec_i,
  input logic             ctrl_i,
  input logic [7:0]       instr_i,
  input logic             sep_data_i,
  input logic             cond_o,
  input logic [15:0]      op_hit,
  input logic [IOB_N-1:0] iob_o,
  input logic             unit_sel_o,
  input logic             head_load_o,
  input logic             wbuf_o,
  input logic             jk_flag_o,
  input logic [BAR_W-1:0] bar_o,
  input logic [CRC_W-1:0] crc_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [SR_W-1:0]  sr_o
);
  logic [3:0] fld;
  logic       fire;
  assign fld  = instr_i[5:2];
  assign fire = exec_i & ctrl_i;

  // R9: at most one operation strobe, none without a fired control instruction
  p_one_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_hit) && (fire || op_hit == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire || fld == 4'd15) |=>
      $stable({iob_o, unit_sel_o, head_load_o, wbuf_o, jk_flag_o,
               bar_o, crc_o, cnt_o, sr_o}));

  p_bar_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fld == 4'd9 && instr_i[1]) |=> bar_o == BAR_W'($past(bar_o) + 1'b1));

  p_crc_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fld == 4'd11 && instr_i[1:0] == 2'b11) |=> (&crc_o));

  p_jk_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fld == 4'd12 && instr_i[1:0] == 2'b11) |=> jk_flag_o != $past(jk_flag_o));

  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fld == 4'd13 && instr_i[0]) |=> cnt_o == '0);

  p_cond_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fld == 4'd15) |-> cond_o == jk_flag_o);

  p_cond_undef_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fld inside {4'd0, 4'd2, 4'd3, 4'd7, 4'd8, 4'd9, 4'd10, 4'd13, 4'd14}) |-> !cond_o);
endmodule

bind mseq_ctrl_unit mseq_ctrl_unit_chk #(
  .IOB_N(IOB_N), .BAR_W(BAR_W), .CRC_W(CRC_W), .CNT_W(CNT_W), .SR_W(SR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .ctrl_i(ctrl_i),
  .instr_i(instr_i), .sep_data_i(sep_data_i), .cond_o(cond_o),
  .op_hit(op_hit), .iob_o(iob_o), .unit_sel_o(unit_sel_o),
  .head_load_o(head_load_o), .wbuf_o(wbuf_o), .jk_flag_o(jk_flag_o),
  .bar_o(bar_o), .crc_o(crc_o), .cnt_o(cnt_o), .sr_o(sr_o)
);

// File: tb/tb_mseq_ctrl_unit.sv
module tb_mseq_ctrl_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_i = 1'b0, ctrl_i = 1'b0, sep_data_i = 1'b0;
  logic [7:0] instr_i = 8'h00;
  logic cond_o, unit_sel_o, head_load_o, wbuf_o, jk_flag_o;
  logic [6:0] iob_o;
  logic [11:0] bar_o;
  logic [15:0] crc_o;
  logic [7:0] cnt_o, sr_o;

  always #5 clk = ~clk;

  mseq_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .ctrl_i(ctrl_i),
    .instr_i(instr_i), .sep_data_i(sep_data_i), .cond_o(cond_o),
    .iob_o(iob_o), .unit_sel_o(unit_sel_o), .head_load_o(head_load_o),
    .wbuf_o(wbuf_o), .jk_flag_o(jk_flag_o), .bar_o(bar_o), .crc_o(crc_o),
    .cnt_o(cnt_o), .sr_o(sr_o)
  );

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // bench-side reference state
  logic [6:0] m_iob;  logic m_unit, m_head, m_wbuf, m_jk;
  logic [11:0] m_bar; logic [15:0] m_crc; logic [7:0] m_cnt, m_sr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic ref_cond(input int f, input logic sep);
    case (f)
      1:  return m_iob[3];
      4:  return m_sr[7];
      5:  return m_cnt == 8'd255;
      6:  return m_crc[0];
      11: return m_sr[7] ~^ sep;
      12: return m_bar == 12'd4095;
      15: return m_jk;
      default: return 1'b0;
    endcase
  endfunction

  task automatic ref_apply(input logic ex, input logic ct, input logic [7:0] ins);
    int f; logic b1, b0;
    f = int'(ins[5:2]); b1 = ins[1]; b0 = ins[0];
    if (!(ex && ct)) return;
    if (f <= 6) m_iob[f] = b1;
    else if (f == 7) m_unit = b1;
    else if (f == 8) m_head = b1;
    else if (f == 9) m_bar = b1 ? 12'((m_bar + 1) % 4096) : (b0 ? 12'd0 : 12'd3072);
    else if (f == 10) m_wbuf = b0;
    else if (f == 11) begin
      if (b1 && b0) m_crc = 16'hFFFF;
      else if (b1) m_crc = {1'b0, m_crc[15:1]};
    end else if (f == 12) begin
      if (b1 && b0) m_jk = !m_jk;
      else if (b1) m_jk = 1'b1;
      else if (b0) m_jk = 1'b0;
    end else if (f == 13) begin
      if (b0) m_cnt = 8'd0;
      else if (b1) m_cnt = 8'((m_cnt + 1) % 256);
    end else if (f == 14) m_sr = {m_sr[6:0], b1};
  endtask

  task automatic cmp_state(input bit quiet_tag);
    if (quiet_tag) begin
      chk("R9 state held", {iob_o, unit_sel_o, head_load_o, wbuf_o, jk_flag_o},
          {m_iob, m_unit, m_head, m_wbuf, m_jk});
      chk("R9 words held", {bar_o, crc_o}, {m_bar, m_crc});
      chk("R9 cnt/sr held", {cnt_o, sr_o}, {m_cnt, m_sr});
    end else begin
      chk("R2 iob", iob_o, m_iob);
      chk("R3 unit/head", {unit_sel_o, head_load_o}, {m_unit, m_head});
      chk("R4 bar", bar_o, m_bar);
      chk("R5 wbuf", wbuf_o, m_wbuf);
      chk("R6 crc", crc_o, m_crc);
      chk("R7 jk", jk_flag_o, m_jk);
      chk("R8 cnt/sr", {cnt_o, sr_o}, {m_cnt, m_sr});
    end
  endtask

  // one instruction: drive at negedge, test condition, check state one edge later
  task automatic step(input logic ex, input logic ct, input logic [7:0] ins, input logic sep);
    int f; bit undef_f; bit no_change;
    f = int'(ins[5:2]);
    exec_i = ex; ctrl_i = ct; instr_i = ins; sep_data_i = sep;
    #1;
    undef_f = !(f inside {1, 4, 5, 6, 11, 12, 15});
    if (undef_f) chk("R11 cond", cond_o, 1'b0);
    else         chk("R10 cond", cond_o, ref_cond(f, sep));
    no_change = !(ex && ct) || f == 15;
    ref_apply(ex, ct, ins);
    @(negedge clk);
    cmp_state(no_change);
  endtask

  function automatic logic [7:0] mk(input int f, input int b);
    return {2'b00, 4'(f), 2'(b)};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    m_iob = '0; m_unit = 0; m_head = 0; m_wbuf = 0; m_jk = 0;
    m_bar = '0; m_crc = '0; m_cnt = '0; m_sr = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset regs", {iob_o, unit_sel_o, head_load_o, wbuf_o, jk_flag_o}, 32'd0);
    chk("R1 reset words", {bar_o, crc_o, cnt_o, sr_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {bar_o, crc_o}, 32'd0);

    // R2/R3/R5: write each single-bit register high then low
    for (int f = 0; f <= 8; f++) step(1, 1, mk(f, 2), 0);
    step(1, 1, mk(10, 1), 0);
    step(1, 0, mk(1, 0), 0);          // R10 iob3 test
    for (int f = 0; f <= 8; f++) step(1, 1, mk(f, 0), 0);
    step(1, 1, mk(10, 0), 0);

    // R7: J-K set, hold, toggle, clear
    step(1, 1, mk(12, 2), 0);
    step(1, 1, mk(12, 0), 0);
    step(1, 0, mk(15, 0), 0);
    step(1, 1, mk(12, 3), 0);
    step(1, 1, mk(12, 3), 0);
    step(1, 1, mk(12, 1), 0);

    // R9: strobes low or field 15 change nothing
    step(0, 1, mk(12, 3), 0);
    step(1, 0, mk(11, 3), 0);
    step(1, 1, mk(15, 3), 0);

    // R6: preset, shift, no-op
    step(1, 1, mk(11, 3), 0);
    step(1, 0, mk(6, 0), 0);
    step(1, 1, mk(11, 2), 0);
    step(1, 1, mk(11, 1), 0);

    // R4: load high half, run to 4095, test, wrap; load 0
    step(1, 1, mk(9, 0), 0);
    while (m_bar != 12'd4095) step(1, 1, mk(9, 2), 0);
    step(1, 0, mk(12, 0), 0);
    step(1, 1, mk(9, 2), 0);
    step(1, 1, mk(9, 3), 0);
    step(1, 1, mk(9, 1), 0);

    // R8: count to 255, test, wrap, clear; shift register
    while (m_cnt != 8'd255) step(1, 1, mk(13, 2), 0);
    step(1, 0, mk(5, 0), 0);
    step(1, 1, mk(13, 0), 0);
    step(1, 1, mk(13, 2), 0);
    step(1, 1, mk(13, 3), 0);
    step(1, 1, mk(14, 2), 0);
    step(1, 0, mk(11, 0), 1);
    step(1, 0, mk(11, 0), 0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic ex, ct, sp; logic [7:0] ins;
      ex  = ($urandom % 10) < 8;
      ct  = ($urandom % 10) < 6;
      sp  = 1'($urandom);
      ins = 8'($urandom);
      step(ex, ct, ins, sp);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule